// File: doc/BRIEF.md
# SPI Status and Error Flag Unit

This unit sits next to an SPI shift engine and turns the engine's events into a status word that software can read. It tracks five sticky event flags: word finished, multimaster mode fault, transmit underflow, receive overflow and transmit collision. It also tracks an external-transaction-done flag and reports how full the transmit and receive buffers are. All error-type flags are cleared by writing a one to their bit position.

The unit also decides which word the engine shifts out. When the transmit buffer holds data, that word goes out and is remembered. When the buffer is empty at the moment a word must go out, a send-zero control picks either an all-zero word or a resend of the last word that was loaded.

In multimaster mode, a master that sees its active-low select input pulled low records a mode fault. It also drops its master-enable output on the next clock, so it stops driving the bus. The shift engine, clock generation and bus bridge sit outside this unit and connect through plain ports.

Top module: `spi_stat_unit`

## Requirements
- R1: Status bit 0 (word done) becomes 1 on the clock after a `word_done` pulse. It returns to 0 on the clock after `sw_rx_rd` or `sw_tx_wr`, and a status write has no effect on it.
- R2: Status bit 1 (mode fault) is set on the clock after a cycle in which `master_mode`, `multimaster_en` and a low `sel_n` are all present. If any one of these is missing, it is not set.
- R3: `master_en` follows `master_mode` until a mode fault occurs. From the next clock it is 0, and it stays 0 until `master_mode` is deasserted.
- R4: Status bit 2 (transmit underflow) is set on the clock after a `load_req` that arrives while `tx_level` is 0. A `load_req` while data is present leaves it unchanged.
- R5: `shift_word` equals `tx_data` while `tx_level` is nonzero. When the buffer is empty, it is all zeros if `send_zero` is 1. If `send_zero` is 0, it is the word taken by the last `load_req` that found data, or zero if no such load has happened since reset.
- R6: Status bit 3 (receive overflow) is set when `word_done` arrives while `rx_level` equals DEPTH. In that cycle `rx_push` is 0, so the new word is dropped; otherwise `rx_push` follows `word_done`.
- R7: Status bit 4 (transmit collision) is set when `sw_tx_wr` arrives while `shifting` is 1. It is not set when `shifting` is 0.
- R8: Bits 1, 2, 3, 4 and 9 are write-one-to-clear. A `clr_wr` cycle clears exactly the flags whose `clr_data` bit is 1, one clock later, and leaves the other flags unchanged.
- R9: When a set event and its clear (a write-one, or a read/write for bit 0) fall in the same cycle, the flag ends up set.
- R10: The transmit buffer field is bits 6:5 and the receive buffer field is bits 8:7. Each reads 00 when its level is 0, 11 when its level is DEPTH, and 01 otherwise.
- R11: Status bit 9 (external done) is set on the clock after an `ext_done` pulse.
- R12: After reset every flag is 0, `master_en` is 0 and the remembered word is zero. Bits 15:10 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| word_done | input | 1 | Engine finished one word |
| ext_done | input | 1 | External transaction finished |
| load_req | input | 1 | Engine takes the next word to shift out |
| shifting | input | 1 | Shift from transmit buffer in progress |
| tx_level | input | LVL_W | Transmit buffer occupancy |
| tx_data | input | DATA_W | Word at head of transmit buffer |
| rx_level | input | LVL_W | Receive buffer occupancy |
| sw_tx_wr | input | 1 | Software writes transmit buffer |
| sw_rx_rd | input | 1 | Software reads receive buffer |
| sel_n | input | 1 | Active-low device-select input |
| master_mode | input | 1 | Device configured as master |
| multimaster_en | input | 1 | Multimaster fault checking enabled |
| send_zero | input | 1 | Underflow fill choice: 1 zeros, 0 resend |
| clr_wr | input | 1 | Status write strobe |
| clr_data | input | 16 | Status write data, ones clear flags |
| status | output | 16 | Status word |
| master_en | output | 1 | Master drive enable |
| shift_word | output | DATA_W | Word handed to the shift engine |
| rx_push | output | 1 | Received word may enter the receive buffer |

## Verification
The two functions that can meet in one cycle are a hardware event setting a flag and a software action clearing it.

The bench raises `word_done` against a full receive buffer while writing a one to bit 3 in the same cycle. It also pairs `word_done` with a transmit write or a receive read. In each case it expects the flag to read 1 on the following clock.

A sweep over all 32 clear masks, applied after every error flag has been raised together, checks that each mask clears exactly its own bits and leaves bit 0 alone.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int STAT_W = 16;
  localparam int B_DONE = 0;
  localparam int B_MF   = 1;
  localparam int B_TUNF = 2;
  localparam int B_ROVF = 3;
  localparam int B_TCOL = 4;
  localparam int B_TXS  = 5;
  localparam int B_RXS  = 7;
  localparam int B_EXT  = 9;
  localparam int N_ERR  = 5;

  typedef enum logic [1:0] {
    BUF_EMPTY = 2'b00,
    BUF_PART  = 2'b01,
    BUF_FULL  = 2'b11
  } buf_state_e;
endpackage

// File: rtl/spi_w1c_flag.sv
module spi_w1c_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_d;

  always_comb begin
    q_d = q;
    if (clr) q_d = 1'b0;
    if (set) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end

  // R9: set dominates a simultaneous clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  // R8: a lone clear empties the flag
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
  // R8: without events the flag holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !set) |=> (q == $past(q)));
endmodule

// File: rtl/spi_lvl_enc.sv
module spi_lvl_enc
  import spi_stat_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] level,
  output buf_state_e       state
);
  always_comb begin
    if (level == '0)
      state = BUF_EMPTY;
    else if (32'(level) >= DEPTH)
      state = BUF_FULL;
    else
      state = BUF_PART;
  end
endmodule

// File: rtl/spi_tx_sel.sv
module spi_tx_sel #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic              has_data,
  input  logic              send_zero,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] last_q;
  logic [DATA_W-1:0] last_d;
  logic              last_en;

  assign last_en = ld & has_data;

  always_comb begin
    last_d = last_q;
    if (last_en) last_d = data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= last_d;
  end

  always_comb begin
    if (has_data)       word = data;
    else if (send_zero) word = '0;
    else                word = last_q;
  end

  // R5: an empty load with resend repeats the word loaded one cycle earlier
  a_r5_resend: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !has_data && !send_zero && $past(ld && has_data))
      |-> (word == $past(data)));
endmodule

// File: rtl/spi_stat_unit.sv
module spi_stat_unit
  import spi_stat_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_done,
  input  logic              ext_done,
  input  logic              load_req,
  input  logic              shifting,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              sw_tx_wr,
  input  logic              sw_rx_rd,
  input  logic              sel_n,
  input  logic              master_mode,
  input  logic              multimaster_en,
  input  logic              send_zero,
  input  logic              clr_wr,
  input  logic [15:0]       clr_data,
  output logic [15:0]       status,
  output logic              master_en,
  output logic [DATA_W-1:0] shift_word,
  output logic              rx_push
);
  localparam int ERR_POS [N_ERR] = '{B_MF, B_TUNF, B_ROVF, B_TCOL, B_EXT};

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_i = rs_q[1];

  // event decode
  logic tx_empty, rx_full, fault;
  assign tx_empty = (tx_level == '0);
  assign rx_full  = (32'(rx_level) >= DEPTH);
  assign fault    = master_mode & multimaster_en & ~sel_n;
  assign rx_push  = word_done & ~rx_full;

  logic [N_ERR-1:0] err_set;
  logic [N_ERR-1:0] err_clr;
  logic [N_ERR-1:0] err_q;

  assign err_set[0] = fault;
  assign err_set[1] = load_req & tx_empty;
  assign err_set[2] = word_done & rx_full;
  assign err_set[3] = sw_tx_wr & shifting;
  assign err_set[4] = ext_done;

  for (genvar i = 0; i < N_ERR; i++) begin : g_err
    assign err_clr[i] = clr_wr & clr_data[ERR_POS[i]];
    spi_w1c_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n_i),
      .set   (err_set[i]),
      .clr   (err_clr[i]),
      .q     (err_q[i])
    );
  end

  // word-done flag: cleared by buffer access, never by status write
  logic done_q, done_d;
  always_comb begin
    done_d = done_q;
    if (sw_rx_rd | sw_tx_wr) done_d = 1'b0;
    if (word_done)           done_d = 1'b1;
  end
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) done_q <= 1'b0;
    else          done_q <= done_d;
  end

  // master drop latch
  logic kill_q, kill_d;
  always_comb begin
    kill_d = kill_q;
    if (!master_mode) kill_d = 1'b0;
    else if (fault)   kill_d = 1'b1;
  end
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) kill_q <= 1'b0;
    else          kill_q <= kill_d;
  end
  assign master_en = master_mode & ~kill_q;

  // buffer status
  buf_state_e tx_st, rx_st;
  spi_lvl_enc #(.DEPTH(DEPTH)) u_tx_enc (.level(tx_level), .state(tx_st));
  spi_lvl_enc #(.DEPTH(DEPTH)) u_rx_enc (.level(rx_level), .state(rx_st));

  // outgoing word choice
  spi_tx_sel #(.DATA_W(DATA_W)) u_tx_sel (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .ld        (load_req),
    .has_data  (~tx_empty),
    .send_zero (send_zero),
    .data      (tx_data),
    .word      (shift_word)
  );

  always_comb begin
    status = '0;
    status[B_DONE] = done_q;
    for (int i = 0; i < N_ERR; i++) status[ERR_POS[i]] = err_q[i];
    status[B_TXS +: 2] = tx_st;
    status[B_RXS +: 2] = rx_st;
  end

  a_r1_done: assert property (@(posedge clk) disable iff (!rst_n_i)
    word_done |=> status[B_DONE]);
  a_r2_fault: assert property (@(posedge clk) disable iff (!rst_n_i)
    (master_mode && multimaster_en && !sel_n) |=> status[B_MF]);
  a_r3_drop: assert property (@(posedge clk) disable iff (!rst_n_i)
    (master_mode && multimaster_en && !sel_n) |=> !master_en);
  a_r4_underflow: assert property (@(posedge clk) disable iff (!rst_n_i)
    (load_req && tx_level == '0) |=> status[B_TUNF]);
  a_r6_overflow: assert property (@(posedge clk) disable iff (!rst_n_i)
    (word_done && !rx_push) |=> status[B_ROVF]);
  a_r7_collision: assert property (@(posedge clk) disable iff (!rst_n_i)
    (sw_tx_wr && shifting) |=> status[B_TCOL]);
endmodule

// File: tb/spi_stat_unit_tb.sv
module spi_stat_unit_tb;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 2;
  localparam int LVL_W  = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic word_done, ext_done, load_req, shifting;
  logic [LVL_W-1:0] tx_level, rx_level;
  logic [DATA_W-1:0] tx_data;
  logic sw_tx_wr, sw_rx_rd, sel_n, master_mode, multimaster_en, send_zero, clr_wr;
  logic [15:0] clr_data;
  logic [15:0] status;
  logic master_en, rx_push;
  logic [DATA_W-1:0] shift_word;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  spi_stat_unit #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .word_done(word_done), .ext_done(ext_done),
    .load_req(load_req), .shifting(shifting), .tx_level(tx_level),
    .tx_data(tx_data), .rx_level(rx_level), .sw_tx_wr(sw_tx_wr),
    .sw_rx_rd(sw_rx_rd), .sel_n(sel_n), .master_mode(master_mode),
    .multimaster_en(multimaster_en), .send_zero(send_zero), .clr_wr(clr_wr),
    .clr_data(clr_data), .status(status), .master_en(master_en),
    .shift_word(shift_word), .rx_push(rx_push)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    word_done = 0; ext_done = 0; load_req = 0; shifting = 0;
    tx_level = 0; rx_level = 0; tx_data = 0; sw_tx_wr = 0; sw_rx_rd = 0;
    sel_n = 1; master_mode = 0; multimaster_en = 0; send_zero = 0;
    clr_wr = 0; clr_data = 0;
  endtask

  function automatic logic [1:0] enc(input int lvl);
    return (lvl == 0) ? 2'b00 : (lvl >= DEPTH) ? 2'b11 : 2'b01;
  endfunction

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();

    // R12 reset state
    chk("R12 status", 32'(status), 0);
    chk("R12 master_en", 32'(master_en), 0);
    chk("R12 shift_word", 32'(shift_word), 0);

    // R10 sweep of buffer levels
    for (int t = 0; t <= DEPTH; t++)
      for (int r = 0; r <= DEPTH; r++) begin
        tx_level = LVL_W'(t); rx_level = LVL_W'(r); #1;
        chk("R10 tx field", 32'(status[6:5]), 32'(enc(t)));
        chk("R10 rx field", 32'(status[8:7]), 32'(enc(r)));
        chk("R12 upper bits", 32'(status[15:10]), 0);
      end
    idle(); tick();

    // R1 word done
    word_done = 1; tick(); word_done = 0;
    chk("R1 set", 32'(status[0]), 1);
    clr_wr = 1; clr_data = 16'h0001; tick(); clr_wr = 0; clr_data = 0;
    chk("R1 status write ignored", 32'(status[0]), 1);
    sw_rx_rd = 1; tick(); sw_rx_rd = 0;
    chk("R1 cleared by read", 32'(status[0]), 0);
    word_done = 1; sw_tx_wr = 1; tick(); word_done = 0; sw_tx_wr = 0;
    chk("R9 done set wins", 32'(status[0]), 1);
    sw_tx_wr = 1; tick(); sw_tx_wr = 0;
    chk("R1 cleared by write", 32'(status[0]), 0);
    chk("R7 no collision when idle", 32'(status[4]), 0);

    // R7 collision
    shifting = 1; sw_tx_wr = 1; tick(); shifting = 0; sw_tx_wr = 0;
    chk("R7 collision", 32'(status[4]), 1);
    clr_wr = 1; clr_data = 16'h0010; tick(); clr_wr = 0; clr_data = 0;
    chk("R8 collision cleared", 32'(status[4]), 0);

    // R6 overflow
    rx_level = 2'(DEPTH); word_done = 1; #1;
    chk("R6 drop word", 32'(rx_push), 0);
    tick(); word_done = 0;
    chk("R6 overflow", 32'(status[3]), 1);
    clr_wr = 1; clr_data = 16'h0008; tick(); clr_wr = 0; clr_data = 0;
    chk("R8 overflow cleared", 32'(status[3]), 0);
    rx_level = 1; word_done = 1; #1;
    chk("R6 push accepted", 32'(rx_push), 1);
    tick();
    chk("R6 no overflow below full", 32'(status[3]), 0);
    rx_level = 2'(DEPTH); clr_wr = 1; clr_data = 16'h0008; tick();
    word_done = 0; clr_wr = 0; clr_data = 0;
    chk("R9 overflow set wins", 32'(status[3]), 1);
    clr_wr = 1; clr_data = 16'h0008; sw_rx_rd = 1; rx_level = 0; tick();
    clr_wr = 0; clr_data = 0; sw_rx_rd = 0;

    // R4 / R5 underflow and fill choice
    load_req = 1; tx_level = 0; send_zero = 0; #1;
    chk("R5 resend after reset", 32'(shift_word), 0);
    tick(); load_req = 0;
    chk("R4 underflow", 32'(status[2]), 1);
    clr_wr = 1; clr_data = 16'h0004; tick(); clr_wr = 0; clr_data = 0;
    chk("R8 underflow cleared", 32'(status[2]), 0);
    tx_level = 1; tx_data = 8'hA5; load_req = 1; #1;
    chk("R5 data path", 32'(shift_word), 32'h A5);
    tick(); load_req = 0;
    chk("R4 no underflow with data", 32'(status[2]), 0);
    tx_level = 0; tx_data = 8'h3C; #1;
    chk("R5 resend last", 32'(shift_word), 32'h A5);
    send_zero = 1; #1;
    chk("R5 zero fill", 32'(shift_word), 0);
    idle(); tick();

    // R11 external done
    ext_done = 1; tick(); ext_done = 0;
    chk("R11 ext done", 32'(status[9]), 1);
    clr_wr = 1; clr_data = 16'h0200; tick(); clr_wr = 0; clr_data = 0;
    chk("R8 ext cleared", 32'(status[9]), 0);

    // R2 / R3 sweep of fault conditions
    for (int c = 0; c < 8; c++) begin
      logic mm, me, sn, flt;
      idle(); clr_wr = 1; clr_data = 16'h0002; tick(); clr_wr = 0; clr_data = 0;
      mm = c[0]; me = c[1]; sn = c[2];
      flt = mm & me & ~sn;
      master_mode = mm; multimaster_en = me; sel_n = sn; #1;
      chk("R3 follows master_mode", 32'(master_en), 32'(mm));
      tick();
      chk("R2 fault flag", 32'(status[1]), 32'(flt));
      chk("R3 drop", 32'(master_en), 32'(mm & ~flt));
      if (flt) begin
        sel_n = 1; tick();
        chk("R3 stays dropped", 32'(master_en), 0);
      end
    end
    idle(); tick();

    // R8 sweep of all clear masks
    for (int p = 0; p < 32; p++) begin
      logic [15:0] m;
      m = 16'(((p >> 4) & 1) << 9) | 16'(((p >> 3) & 1) << 4) |
          16'(((p >> 2) & 1) << 3) | 16'(((p >> 1) & 1) << 2) |
          16'((p & 1) << 1);
      word_done = 1; rx_level = 2'(DEPTH); ext_done = 1; shifting = 1;
      sw_tx_wr = 1; load_req = 1; tx_level = 0; master_mode = 1;
      multimaster_en = 1; sel_n = 0;
      tick();
      idle(); tick();
      clr_wr = 1; clr_data = m; tick(); clr_wr = 0; clr_data = 0;
      chk("R8 mask sweep", 32'(status & 16'h021F), 32'((16'h021E & ~m) | 16'h0001));
      clr_wr = 1; clr_data = 16'h021E; sw_rx_rd = 1; tick();
      clr_wr = 0; clr_data = 0; sw_rx_rd = 0;
    end
    chk("R12 all clear at end", 32'(status), 0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule